// File: doc/BRIEF.md
# Mode-Banked Register File

This block is a sixteen-register, two-read, one-write register file. The physical storage behind a register depends on the processor mode that is currently applied. The low half of the register set and the program-counter slot resolve to the same storage in every mode. Registers 8 to 12 get a second copy that only the fast-interrupt mode uses. The stack-pointer and link slots (13 and 14) get a private copy in each of the five exception modes.

A mode switch only changes which physical slot each index selects, and no data moves. An interrupted context therefore stays untouched and reappears when the mode returns. Reads are combinational. Writes commit on the rising clock edge, so a read of the slot being written in the same cycle still returns the old value.

The surrounding core drives the mode, the read addresses and the write port. The block never decides on mode changes itself. Every port is a plain control or data pin, with no handshake and no back-pressure.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 address one shared set of storage; a value written in any mode code reads back at the same index in every mode code.
- R2: Index 15 is shared across all mode codes in the same way as R1.
- R3: With mode code 1 (fast interrupt), indices 8 to 12 select a private copy. Every other mode code selects the user copy of 8 to 12, and a write in one copy leaves the other unchanged.
- R4: Indices 13 and 14 select a private pair for each of mode codes 1, 2, 3, 4 and 5; mode code 0 uses the user pair; a write to one pair is invisible through every other pair.
- R5: A mode change copies no data; after switching away and back, every register shows the value it held before the switch.
- R6: Mode codes 6 and 7 behave exactly as mode code 0 (user).
- R7: A write with the write enable high in mode M at index r changes only the slot that a read of r in mode M returns, and that read returns the written data from the next cycle on.
- R8: A read of the slot being written in the same cycle returns the value held before the clock edge.
- R9: A synchronous, active-high reset clears all 31 physical slots to zero and takes priority over a write in the same cycle.
- R10: With the write enable low, no slot changes; a read with unchanged mode and address returns the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all slots |
| mode | input | 3 | Current mode code (0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6/7 as user) |
| ra_addr | input | 4 | Architectural index for read port A |
| ra_data | output | DATA_W | Combinational data of read port A |
| rb_addr | input | 4 | Architectural index for read port B |
| rb_data | output | DATA_W | Combinational data of read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Architectural index for the write |
| wr_data | input | DATA_W | Write data |

## Verification
The bench builds the block at its default 32-bit data width. At that width, random full-width words make any wrong slot selection or stale value show up as a mismatch rather than a coincidental match. Because the mode code is drawn over all eight values and the indices over all sixteen, random traffic reaches all 31 physical slots, the two undefined mode codes and same-cycle read/write collisions. Directed sequences cover copy isolation for each banked group, persistence across a mode round trip, and a reset that lands on a pending write, followed by a sweep of every mode and index.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  // architectural view
  localparam int ARCH_N  = 16;
  localparam int ARCH_W  = $clog2(ARCH_N);
  localparam int FIQ_LO  = 8;
  localparam int FIQ_HI  = 12;
  localparam int SP_IDX  = 13;
  localparam int LR_IDX  = 14;

  // banking geometry
  localparam int FIQ_N     = FIQ_HI - FIQ_LO + 1;
  localparam int EXC_MODES = 5;
  localparam int EXC_PER   = LR_IDX - SP_IDX + 1;
  localparam int FIQ_BASE  = ARCH_N;
  localparam int EXC_BASE  = ARCH_N + FIQ_N;
  localparam int PHYS_N    = EXC_BASE + EXC_MODES * EXC_PER;
  localparam int PHYS_W    = $clog2(PHYS_N);

  // mode codes
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_USR = 3'd0;
  localparam logic [MODE_W-1:0] MODE_FIQ = 3'd1;
  localparam logic [MODE_W-1:0] MODE_IRQ = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SVC = 3'd3;
  localparam logic [MODE_W-1:0] MODE_ABT = 3'd4;
  localparam logic [MODE_W-1:0] MODE_UND = 3'd5;

  function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
    return (m >= MODE_FIQ) && (m <= MODE_UND);
  endfunction
endpackage

// File: rtl/bankrf_slot_map.sv
module bankrf_slot_map
  import bankrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [ARCH_W-1:0] idx,
  output logic [PHYS_W-1:0] slot
);
  int i_v;
  int m_v;
  int s_v;

  always_comb begin
    i_v = int'(idx);
    m_v = int'(mode);
    s_v = i_v;
    if (mode == MODE_FIQ && i_v >= FIQ_LO && i_v <= FIQ_HI) begin
      s_v = FIQ_BASE + (i_v - FIQ_LO);
    end else if (is_exc_mode(mode) && (i_v == SP_IDX || i_v == LR_IDX)) begin
      s_v = EXC_BASE + EXC_PER * (m_v - int'(MODE_FIQ)) + (i_v - SP_IDX);
    end
    slot = PHYS_W'(s_v);
  end
endmodule

// File: rtl/bankrf_store.sv
module bankrf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we && int'(waddr) < DEPTH) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (int'(raddr[g]) < DEPTH) ? mem[raddr[g]] : '0;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [3:0]        ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NRD  = 2;
  localparam int NMAP = NRD + 1;

  logic [NMAP-1:0][ARCH_W-1:0] arch_idx;
  logic [NMAP-1:0][PHYS_W-1:0] phys_idx;
  logic [NRD-1:0][PHYS_W-1:0]  rd_slot;
  logic [NRD-1:0][DATA_W-1:0]  rd_word;

  // port 0 = read A, port 1 = read B, last = write
  assign arch_idx = {wr_addr, rb_addr, ra_addr};

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    bankrf_slot_map u_map (
      .mode (mode),
      .idx  (arch_idx[g]),
      .slot (phys_idx[g])
    );
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rsel
    assign rd_slot[g] = phys_idx[g];
  end

  bankrf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_N),
    .NRD    (NRD)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (phys_idx[NMAP-1]),
    .wdata (wr_data),
    .raddr (rd_slot),
    .rdata (rd_word)
  );

  assign ra_data = rd_word[0];
  assign rb_data = rd_word[1];
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode,
  input logic [3:0]        ra_addr,
  input logic [DATA_W-1:0] ra_data,
  input logic [3:0]        rb_addr,
  input logic [DATA_W-1:0] rb_data,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1: low shared registers visible in any mode next cycle
  a_r1_shared_low: assert property (@(posedge clk) disable iff (rst)
    (started && wr_en && wr_addr < 4'd8) ##1 (ra_addr == $past(wr_addr))
      |-> ra_data == $past(wr_data));

  // R2: program counter slot shared by all modes
  a_r2_shared_pc: assert property (@(posedge clk) disable iff (rst)
    (started && wr_en && wr_addr == 4'd15) ##1 (rb_addr == 4'd15)
      |-> rb_data == $past(wr_data));

  // R7: write in mode M visible to a read in mode M next cycle
  a_r7_write_read: assert property (@(posedge clk) disable iff (rst)
    (started && wr_en) ##1 (mode == $past(mode) && ra_addr == $past(wr_addr))
      |-> ra_data == $past(wr_data));

  // R10: no write, same mode and address -> same data
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && !$past(wr_en) && $stable(mode) && $stable(rb_addr))
      |-> $stable(rb_data));

  // R9: after a reset edge both ports read zero
  a_r9_reset_clears: assert property (@(posedge clk)
    (started && $past(rst)) |-> (ra_data == '0 && rb_data == '0));
endmodule

bind banked_regfile bankrf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .ra_addr (ra_addr),
  .ra_data (ra_data),
  .rb_addr (rb_addr),
  .rb_data (rb_data),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode = '0;
  logic [3:0]    ra_addr = '0;
  logic [3:0]    rb_addr = '0;
  logic [DW-1:0] ra_data;
  logic [DW-1:0] rb_data;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model, organised by bank group
  logic [DW-1:0] usr_m [16];
  logic [DW-1:0] fiq_m [5];
  logic [DW-1:0] exc_m [5][2];

  always #5 clk = ~clk;

  banked_regfile #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic bit fiq_sel(input logic [2:0] m, input logic [3:0] r);
    return (m == 3'd1) && (r >= 4'd8) && (r <= 4'd12);
  endfunction

  function automatic bit exc_sel(input logic [2:0] m, input logic [3:0] r);
    return (m >= 3'd1) && (m <= 3'd5) && (r == 4'd13 || r == 4'd14);
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [2:0] m, input logic [3:0] r);
    if (fiq_sel(m, r)) return fiq_m[r - 4'd8];
    if (exc_sel(m, r)) return exc_m[m - 3'd1][r - 4'd13];
    return usr_m[r];
  endfunction

  function automatic string grp(input logic [2:0] m, input logic [3:0] r);
    if (m > 3'd5) return "R6";
    if (r < 4'd8) return "R1";
    if (r == 4'd15) return "R2";
    if (r <= 4'd12) return "R3";
    return "R4";
  endfunction

  task automatic model_wr(input logic [2:0] m, input logic [3:0] r, input logic [DW-1:0] d);
    if (fiq_sel(m, r)) fiq_m[r - 4'd8] = d;
    else if (exc_sel(m, r)) exc_m[m - 3'd1][r - 4'd13] = d;
    else usr_m[r] = d;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) usr_m[i] = '0;
    for (int i = 0; i < 5; i++) begin
      fiq_m[i] = '0;
      exc_m[i][0] = '0;
      exc_m[i][1] = '0;
    end
  endtask

  task automatic check(input string note, input string tag, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s/%s: got %h expected %h (mode %0d ra %0d rb %0d)",
               note, tag, got, exp, mode, ra_addr, rb_addr);
    end
  endtask

  // drive at the falling edge, check the combinational reads, then let the edge commit
  task automatic step(input string note, input logic [2:0] m, input logic we,
                      input logic [3:0] wa, input logic [DW-1:0] wd,
                      input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    mode = m; wr_en = we; wr_addr = wa; wr_data = wd;
    ra_addr = a; rb_addr = b;
    #1;
    // R8: a read colliding with this cycle's write still sees the old value
    check(note, (we && a == wa) ? "R8" : grp(m, a), ra_data, exp_rd(m, a));
    check(note, (we && b == wa) ? "R8" : grp(m, b), rb_data, exp_rd(m, b));
    @(posedge clk);
    if (we) model_wr(m, wa, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    model_clear();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset", "R9", ra_data, '0);
    check("reset", "R9", rb_data, '0);
    rst = 1'b0;

    // R4: stack-pointer copies for user and supervisor are separate
    step("R4", 3'd0, 1'b1, 4'd13, 32'hAAAA_0013, 4'd0, 4'd0);
    step("R4", 3'd3, 1'b1, 4'd13, 32'hBBBB_0313, 4'd13, 4'd14);
    step("R4", 3'd0, 1'b0, 4'd0, '0, 4'd13, 4'd14);
    step("R4", 3'd3, 1'b0, 4'd0, '0, 4'd13, 4'd13);
    step("R4", 3'd2, 1'b1, 4'd14, 32'hCCCC_0214, 4'd13, 4'd14);
    step("R4", 3'd4, 1'b0, 4'd0, '0, 4'd14, 4'd13);
    // R6: undefined mode codes fall back to the user pair
    step("R6", 3'd6, 1'b0, 4'd0, '0, 4'd13, 4'd14);
    step("R6", 3'd7, 1'b1, 4'd14, 32'hDDDD_0714, 4'd14, 4'd13);
    step("R6", 3'd0, 1'b0, 4'd0, '0, 4'd14, 4'd13);
    // R3: fast-interrupt copy of 8..12
    step("R3", 3'd1, 1'b1, 4'd9, 32'h1111_0109, 4'd9, 4'd12);
    step("R3", 3'd2, 1'b0, 4'd0, '0, 4'd9, 4'd8);
    step("R3", 3'd0, 1'b1, 4'd9, 32'h2222_0009, 4'd9, 4'd9);
    step("R3", 3'd1, 1'b0, 4'd0, '0, 4'd9, 4'd9);
    // R1 / R2: shared registers
    step("R1", 3'd5, 1'b1, 4'd3, 32'h3333_0503, 4'd3, 4'd3);
    step("R1", 3'd1, 1'b0, 4'd0, '0, 4'd3, 4'd3);
    step("R2", 3'd4, 1'b1, 4'd15, 32'h4444_0415, 4'd15, 4'd0);
    step("R2", 3'd2, 1'b0, 4'd0, '0, 4'd15, 4'd15);
    // R10: disabled write leaves the slot alone
    step("R10", 3'd0, 1'b0, 4'd3, 32'hDEAD_BEEF, 4'd3, 4'd3);
    step("R10", 3'd0, 1'b0, 4'd0, '0, 4'd3, 4'd3);
    // R8: same-cycle read of the written slot
    step("R8", 3'd3, 1'b1, 4'd14, 32'h5555_0314, 4'd14, 4'd14);
    step("R7", 3'd3, 1'b0, 4'd0, '0, 4'd14, 4'd14);

    // R5: fill every mode, then round-trip through all modes and compare
    for (int m = 0; m < 6; m++)
      for (int r = 0; r < 16; r++)
        step("R5", 3'(m), 1'b1, 4'(r), $urandom, 4'(r), 4'((r + 1) % 16));
    for (int m = 5; m >= 0; m--)
      for (int r = 0; r < 16; r++)
        step("R5", 3'(m), 1'b0, 4'd0, '0, 4'(r), 4'(15 - r));

    // R7: random traffic across all mode codes and indices
    for (int n = 0; n < 3000; n++)
      step("R7", 3'($urandom % 8), 1'($urandom % 2), 4'($urandom % 16), $urandom,
           4'($urandom % 16), 4'($urandom % 16));

    // R9: reset wins over a simultaneous write, then sweep every mode and index
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; mode = 3'd1; wr_addr = 4'd10; wr_data = 32'hFFFF_FFFF;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 16; r += 2)
        step("R9", 3'(m), 1'b0, 4'd0, '0, 4'(r), 4'(r + 1));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule